// File: doc/BRIEF.md
# Random Replacement Victim Selector

This block decides which way of a missed cache set is evicted on a read miss. The cache presents the valid and modified status bits of every way in the missed set, along with a one-cycle miss strobe. The same selector serves every set, because only the status bits of the set being refilled reach it. One cycle later the block returns the chosen way and a flag. The flag says whether that way holds modified data, which must be copied back to memory before the refill overwrites it.

The choice is made in stages. An empty (invalid) way is always used first, and the lowest-numbered one is taken. When every way holds a line, the block draws a number from a free-running linear feedback shift register. It then prefers ways that are still clean, so that no write-back is needed. If the drawn way is not allowed, the search rotates upward from it until it reaches an allowed way. The write-back transfer, the refill and the tag store belong to other blocks.

Top module: `victim_select`

## Requirements
- R1: While reset (rstN low) is asserted and right after it is released, done, victimWay and writeBack are all 0.
- R2: done is high in exactly the cycle after each cycle in which missStb is sampled high, and low in all other cycles.
- R3: If any bit of validBits is 0, victimWay is the lowest index whose valid bit is 0, and writeBack is 0, whatever the random draw and the dirty bits are.
- R4: The generator is an 8-bit register. It is set to 8'hA5 in reset and advances on every clock edge out of reset, whether or not a miss is present, to {s[6:0], s[7]^s[5]^s[4]^s[3]}. The draw for a miss is the low log2(NUM_WAYS) bits of the state at the edge that samples missStb.
- R5: If all ways are valid and at least one dirtyBits bit is 0, the victim is the first clean way found when scanning upward from the drawn way, wrapping from NUM_WAYS-1 to 0. writeBack is 0.
- R6: If all ways are valid and all are dirty, victimWay equals the drawn way and writeBack is 1.
- R7: victimWay and writeBack keep their values in every cycle that does not follow a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missStb | input | 1 | Read miss strobe, one cycle per miss |
| validBits | input | NUM_WAYS | Valid bit of each way of the missed set |
| dirtyBits | input | NUM_WAYS | Modified bit of each way of the missed set |
| victimWay | output | log2(NUM_WAYS) | Selected way to overwrite |
| writeBack | output | 1 | Selected way is modified and must be written back first |
| done | output | 1 | Result valid, one cycle after missStb |

## Verification
The assertions check on every cycle that done follows each miss by exactly one cycle. They also check three properties of the result against the status bits latched at the miss: an invalid way is chosen when one exists, and it is the lowest such way; a clean way is preferred among valid ways; writeBack is raised only when every way is dirty. Two behaviours depend on the exact generator sequence and are shown only by the bench: which clean way the rotating search reaches from the draw, and which way is drawn when all ways are dirty. To show them, the bench keeps its own model of the shift register and compares against it over random status patterns and miss spacings, together with directed corner cases.

// File: rtl/victim_pkg.sv
package victim_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // latch a new decision this edge
    logic done;     // result register holds a fresh decision
  } ctrlStrobes_t;
endpackage

// File: rtl/victim_lfsr.sv
module victim_lfsr #(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAP_MASK = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [LFSR_W-1:0] state
);
  logic feedBack;

  assign feedBack = ^(state & TAP_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else       state <= {state[LFSR_W-2:0], feedBack};
  end
endmodule

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missStb,
  output ctrlStrobes_t strobes
);
  logic doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= missStb;
  end

  assign strobes.capture = missStb;
  assign strobes.done    = doneQ;
endmodule

// File: rtl/victim_dp.sv
module victim_dp
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LFSR_W   = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic [NUM_WAYS-1:0] dirtyBits,
  input  logic [LFSR_W-1:0]   rndState,
  output logic [WAY_W-1:0]    victimWay,
  output logic                writeBack
);
  logic [WAY_W-1:0]    draw;
  logic [NUM_WAYS-1:0] cleanMask;
  logic [NUM_WAYS-1:0] allowMask;
  logic                anyInvalid;
  logic                anyClean;
  logic [WAY_W-1:0]    lowInvalid;
  logic [WAY_W-1:0]    rotPick;
  logic [WAY_W-1:0]    nextWay;
  logic                nextWb;
  logic                foundInv;
  logic                foundRot;

  assign draw       = rndState[WAY_W-1:0];
  assign anyInvalid = ~&validBits;
  assign cleanMask  = ~dirtyBits;
  assign anyClean   = |cleanMask;
  assign allowMask  = anyClean ? cleanMask : {NUM_WAYS{1'b1}};

  // Stage 1: lowest invalid way
  always_comb begin
    lowInvalid = '0;
    foundInv   = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!foundInv && !validBits[i]) begin
        lowInvalid = WAY_W'(i);
        foundInv   = 1'b1;
      end
    end
  end

  // Stage 2: rotate upward from the draw to the first allowed way
  always_comb begin
    rotPick  = draw;
    foundRot = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      logic [WAY_W-1:0] idx;
      idx = draw + WAY_W'(i);
      if (!foundRot && allowMask[idx]) begin
        rotPick  = idx;
        foundRot = 1'b1;
      end
    end
  end

  always_comb begin
    if (anyInvalid) begin
      nextWay = lowInvalid;
      nextWb  = 1'b0;
    end else begin
      nextWay = rotPick;
      nextWb  = dirtyBits[rotPick];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimWay <= '0;
      writeBack <= 1'b0;
    end else if (strobes.capture) begin
      victimWay <= nextWay;
      writeBack <= nextWb;
    end
  end
endmodule

// File: rtl/victim_select.sv
module victim_select
  import victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LFSR_W   = 8,
  parameter logic [LFSR_W-1:0] TAP_MASK = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED     = 8'hA5,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                missStb,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic [NUM_WAYS-1:0] dirtyBits,
  output logic [WAY_W-1:0]    victimWay,
  output logic                writeBack,
  output logic                done
);
  ctrlStrobes_t      strobes;
  logic [LFSR_W-1:0] rndState;

  victim_lfsr #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) uLfsr (
    .clk(clk), .rstN(rstN), .state(rndState)
  );

  victim_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .missStb(missStb), .strobes(strobes)
  );

  victim_dp #(.NUM_WAYS(NUM_WAYS), .LFSR_W(LFSR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .validBits(validBits), .dirtyBits(dirtyBits), .rndState(rndState),
    .victimWay(victimWay), .writeBack(writeBack)
  );

  assign done = strobes.done;
endmodule

// File: rtl/victim_select_checker.sv
module victim_select_checker #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                missStb,
  input logic [NUM_WAYS-1:0] validBits,
  input logic [NUM_WAYS-1:0] dirtyBits,
  input logic [WAY_W-1:0]    victimWay,
  input logic                writeBack,
  input logic                done
);
  logic [NUM_WAYS-1:0] lastValid;
  logic [NUM_WAYS-1:0] lastDirty;
  logic [NUM_WAYS-1:0] belowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValid <= '0;
      lastDirty <= '0;
    end else if (missStb) begin
      lastValid <= validBits;
      lastDirty <= dirtyBits;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) belowMask[i] = (i < int'(victimWay));
  end

  p_done_after_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    missStb |=> done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !missStb |=> !done);
  p_invalid_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(&lastValid)) |-> (!lastValid[victimWay] && !writeBack &&
                                 ((lastValid & belowMask) == belowMask)));
  p_clean_preferred_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && (&lastValid) && !(&lastDirty)) |-> (!lastDirty[victimWay] && !writeBack));
  p_all_dirty_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && (&lastValid) && (&lastDirty)) |-> writeBack);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !missStb |=> ($stable(victimWay) && $stable(writeBack)));
endmodule

bind victim_select victim_select_checker #(.NUM_WAYS(NUM_WAYS)) uChk (
  .clk(clk), .rstN(rstN), .missStb(missStb), .validBits(validBits),
  .dirtyBits(dirtyBits), .victimWay(victimWay), .writeBack(writeBack), .done(done)
);

// File: tb/victim_select_test.sv
`timescale 1ns/1ps
module victim_select_test;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                missStb = 1'b0;
  logic [NUM_WAYS-1:0] validBits = '0;
  logic [NUM_WAYS-1:0] dirtyBits = '0;
  logic [WAY_W-1:0]    victimWay;
  logic                writeBack;
  logic                done;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  victim_select #(.NUM_WAYS(NUM_WAYS)) uut (
    .clk(clk), .rstN(rstN), .missStb(missStb), .validBits(validBits),
    .dirtyBits(dirtyBits), .victimWay(victimWay), .writeBack(writeBack), .done(done)
  );

  // Model of the generator, from R4
  logic [7:0]       mLfsr;
  logic [WAY_W-1:0] expWay;
  logic             expWb;
  logic             expDone;
  string            expTag;

  function automatic logic [7:0] lfsrNext(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // Returns {writeBack, way} per R3/R5/R6
  function automatic logic [WAY_W:0] pickVictim(input logic [NUM_WAYS-1:0] v,
                                                input logic [NUM_WAYS-1:0] d,
                                                input logic [WAY_W-1:0] dr);
    for (int i = 0; i < NUM_WAYS; i++)
      if (!v[i]) return {1'b0, WAY_W'(i)};
    if (d != {NUM_WAYS{1'b1}}) begin
      for (int k = 0; k < NUM_WAYS; k++) begin
        int w;
        w = (int'(dr) + k) % NUM_WAYS;
        if (!d[w]) return {1'b0, WAY_W'(w)};
      end
    end
    return {1'b1, dr};
  endfunction

  function automatic string classify(input logic [NUM_WAYS-1:0] v,
                                     input logic [NUM_WAYS-1:0] d);
    if (v != {NUM_WAYS{1'b1}}) return "R3";
    if (d != {NUM_WAYS{1'b1}}) return "R5/R4";
    return "R6/R4";
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLfsr   <= 8'hA5;
      expWay  <= '0;
      expWb   <= 1'b0;
      expDone <= 1'b0;
      expTag  <= "R1";
    end else begin
      expDone <= missStb;
      if (missStb) begin
        logic [WAY_W:0] r;
        r = pickVictim(validBits, dirtyBits, mLfsr[WAY_W-1:0]);
        expWay <= r[WAY_W-1:0];
        expWb  <= r[WAY_W];
        expTag <= classify(validBits, dirtyBits);
      end else begin
        expTag <= "R7";
      end
      mLfsr <= lfsrNext(mLfsr);
    end
  end

  task automatic checkOutputs();
    vectors++;
    if (done !== expDone) begin
      fails++;
      $display("FAIL R2 done: actual %0b expected %0b", done, expDone);
    end
    if (victimWay !== expWay || writeBack !== expWb) begin
      fails++;
      $display("FAIL %s way/wb: actual %0d/%0b expected %0d/%0b",
               expTag, victimWay, writeBack, expWay, expWb);
    end
  endtask

  task automatic applyMiss(input logic [NUM_WAYS-1:0] v, input logic [NUM_WAYS-1:0] d);
    validBits = v;
    dirtyBits = d;
    missStb   = 1'b1;
    @(negedge clk);
    missStb   = 1'b0;
    checkOutputs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      validBits = 4'($urandom);
      dirtyBits = 4'($urandom);
      @(negedge clk);
      checkOutputs();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    checkOutputs();
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs();  // R1 right after release

    // Directed corners
    applyMiss(4'b0000, 4'b1111);  // R3: all invalid -> way 0
    applyMiss(4'b1011, 4'b1111);  // R3: way 2 lowest invalid
    applyMiss(4'b0111, 4'b0000);  // R3: way 3 only invalid
    idle(2);                      // R7 hold
    applyMiss(4'b1111, 4'b1111);  // R6: drawn way, writeBack
    applyMiss(4'b1111, 4'b0111);  // R5: only way 3 clean
    applyMiss(4'b1111, 4'b1110);  // R5: only way 0 clean, wrap
    applyMiss(4'b1111, 4'b0000);  // R5: all clean -> drawn way
    idle(5);                      // R4: generator advances with no miss
    applyMiss(4'b1111, 4'b1111);  // R6 after idle gap

    // Constrained random: mostly full sets, varying dirty density and gaps
    for (int n = 0; n < 600; n++) begin
      logic [NUM_WAYS-1:0] v;
      logic [NUM_WAYS-1:0] d;
      v = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b1111;
      d = ($urandom_range(0, 2) == 0) ? 4'b1111 : (4'($urandom) | 4'($urandom));
      applyMiss(v, d);
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 4));
    end
    idle(3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule